// File: doc/BRIEF.md
# Register-cached operand stack datapath

This block is the data side of a stack-oriented microcoded processor. The two uppermost stack entries sit in registers, the top (TOS) and the next one down (NOS). Every older entry is kept in a small synchronous on-chip RAM. Each cycle the decode stage presents one already-decoded stack operation: push an immediate, pop, a binary ALU operation, duplicate, swap or no operation. The operation then passes through two internal stages.

In the decode stage the block works out the RAM addresses and whether the operation must be refused. It uses a look-ahead entry count that already includes the operation one stage ahead, in execute. The read address is registered into the RAM, so fill data is ready when execute starts. In the execute stage the ALU works on NOS and TOS. In the same cycle NOS is spilled to RAM or refilled from it, and TOS and NOS take their new values. There is no separate memory or write-back stage. The RAM is read-old on a same-address collision, so a spill that is immediately followed by a fill of the same slot is forwarded around it.

The reported depth is the number of entries held in RAM, from 0 to DEPTH. Both registers always hold a value, and both are zero after reset.

Top module: `stack_cache`

## Requirements
- R1: After reset, tos_o, nos_o and depth_o are zero and ovf_o and unf_o are low.
- R2: A push (op_i=1) in an accepted state behaves as follows: TOS takes imm_i, NOS takes the previous TOS, the previous NOS is stored in RAM and depth_o rises by one.
- R3: A pop (op_i=2) in an accepted state behaves as follows: TOS takes the previous NOS, NOS takes the most recently stored RAM entry and depth_o falls by one.
- R4: A binary operation (op_i=3) writes NOS op TOS to TOS, refills NOS from RAM and lowers depth_o by one. The alu_sel_i codes are 0 for add, 1 for NOS minus TOS, 2 for AND and 3 for XOR.
- R5: Duplicate (op_i=4) stores NOS in RAM, copies TOS into NOS, leaves TOS unchanged and raises depth_o by one. Swap (op_i=5) exchanges TOS and NOS and leaves depth_o unchanged.
- R6: An operation presented before rising edge n is visible on the outputs after rising edge n+2. One operation is accepted every cycle with no bubble, whatever the mix of operations.
- R7: A pop or binary operation issued in the cycle right after a push or duplicate receives the value that was just spilled as its new NOS.
- R8: A push or duplicate while depth_o equals DEPTH is refused. ovf_o is high for that operation's result cycle, and TOS, NOS and depth_o are left unchanged.
- R9: A pop or binary operation while depth_o is zero is refused. unf_o is high for that operation's result cycle, and TOS, NOS and depth_o are left unchanged.
- R10: op_i codes 0, 6 and 7 change none of tos_o, nos_o or depth_o and raise no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_i | input | 3 | Decoded stack operation code |
| alu_sel_i | input | 2 | Binary operation select |
| imm_i | input | W | Value for a push |
| tos_o | output | W | Top-of-stack register |
| nos_o | output | W | Next-on-stack register |
| depth_o | output | clog2(DEPTH+1) | Entries held in stack RAM |
| ovf_o | output | 1 | Operation refused on a full RAM |
| unf_o | output | 1 | Operation refused on an empty RAM |

## Verification
The checker assumes that op_i and alu_sel_i always carry known values, from reset onward. It relates a refused or register-only operation to the outputs exactly three sampling edges later. Its cause checks stay disarmed until three edges have passed since reset, so operation codes held during reset are never linked to a result. The stimulus drives the no-op code during reset and presents a defined code, select and immediate on every cycle afterwards. It runs directed sequences that fill the RAM past full and drain it past empty, pairs every spill with an immediate fill, and then runs a long random mix weighted so the depth travels across its whole range.

// File: rtl/stk_pkg.sv
package stk_pkg;
  localparam logic [2:0] OP_NOP  = 3'd0;
  localparam logic [2:0] OP_PUSH = 3'd1;
  localparam logic [2:0] OP_POP  = 3'd2;
  localparam logic [2:0] OP_ALU  = 3'd3;
  localparam logic [2:0] OP_DUP  = 3'd4;
  localparam logic [2:0] OP_SWAP = 3'd5;

  localparam logic [1:0] ALU_ADD = 2'd0;
  localparam logic [1:0] ALU_SUB = 2'd1;
  localparam logic [1:0] ALU_AND = 2'd2;
  localparam logic [1:0] ALU_XOR = 2'd3;

  function automatic logic is_grow(input logic [2:0] op);
    return (op == OP_PUSH) || (op == OP_DUP);
  endfunction

  function automatic logic is_shrink(input logic [2:0] op);
    return (op == OP_POP) || (op == OP_ALU);
  endfunction
endpackage

// File: rtl/stk_ram.sv
module stk_ram #(
  parameter int unsigned W     = 16,
  parameter int unsigned DEPTH = 16,
  parameter int unsigned AW    = 4
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [W-1:0]  wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [W-1:0]  rdata_o
);
  logic [W-1:0] mem_q [DEPTH];

  // read-old on collision; caller forwards
  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
    rdata_o <= mem_q[raddr_i];
  end
endmodule

// File: rtl/stk_addr.sv
module stk_addr #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned CW    = 5,
  parameter int unsigned AW    = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          grow_i,
  input  logic          shrink_i,
  output logic          ovf_o,
  output logic          unf_o,
  output logic [AW-1:0] rd_addr_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [CW-1:0] cnt_next_o
);
  // look-ahead count: already includes the op now in execute
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_dec;

  assign ovf_o     = grow_i && (cnt_q == CW'(DEPTH));
  assign unf_o     = shrink_i && (cnt_q == '0);
  assign cnt_dec   = cnt_q - CW'(1);
  assign rd_addr_o = cnt_dec[AW-1:0];
  assign wr_addr_o = cnt_q[AW-1:0];

  always_comb begin
    cnt_next_o = cnt_q;
    if (grow_i && !ovf_o)        cnt_next_o = cnt_q + CW'(1);
    else if (shrink_i && !unf_o) cnt_next_o = cnt_dec;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_next_o;
  end
endmodule

// File: rtl/stk_alu.sv
module stk_alu #(
  parameter int unsigned W = 16
) (
  input  logic [1:0]   sel_i,
  input  logic [W-1:0] nos_i,
  input  logic [W-1:0] tos_i,
  output logic [W-1:0] res_o
);
  import stk_pkg::*;

  always_comb begin
    unique case (sel_i)
      ALU_ADD: res_o = nos_i + tos_i;
      ALU_SUB: res_o = nos_i - tos_i;
      ALU_AND: res_o = nos_i & tos_i;
      ALU_XOR: res_o = nos_i ^ tos_i;
      default: res_o = '0;
    endcase
  end
endmodule

// File: rtl/stack_cache.sv
module stack_cache #(
  parameter int unsigned W     = 16,
  parameter int unsigned DEPTH = 16
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [2:0]                   op_i,
  input  logic [1:0]                   alu_sel_i,
  input  logic [W-1:0]                 imm_i,
  output logic [W-1:0]                 tos_o,
  output logic [W-1:0]                 nos_o,
  output logic [$clog2(DEPTH+1)-1:0]   depth_o,
  output logic                         ovf_o,
  output logic                         unf_o
);
  import stk_pkg::*;

  localparam int unsigned CW = $clog2(DEPTH + 1);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  // decode stage
  logic [2:0]    dec_op_q;
  logic [1:0]    dec_sel_q;
  logic [W-1:0]  dec_imm_q;
  logic          dec_ovf, dec_unf;
  logic [AW-1:0] dec_rd_addr, dec_wr_addr;
  logic [CW-1:0] dec_cnt_next;

  // execute stage
  logic [2:0]    ex_op_q;
  logic [1:0]    ex_sel_q;
  logic [W-1:0]  ex_imm_q;
  logic          ex_ovf_q, ex_unf_q;
  logic [AW-1:0] ex_waddr_q;
  logic [CW-1:0] ex_cnt_q;

  logic [W-1:0]  tos_q, nos_q;
  logic [CW-1:0] depth_q;
  logic          ovf_q, unf_q;

  logic          ram_we;
  logic [W-1:0]  ram_rdata, fill_data, alu_res;
  logic          fwd_q;
  logic [W-1:0]  fwd_data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dec_op_q  <= OP_NOP;
      dec_sel_q <= '0;
      dec_imm_q <= '0;
    end else begin
      dec_op_q  <= op_i;
      dec_sel_q <= alu_sel_i;
      dec_imm_q <= imm_i;
    end
  end

  stk_addr #(.DEPTH(DEPTH), .CW(CW), .AW(AW)) u_addr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .grow_i     (is_grow(dec_op_q)),
    .shrink_i   (is_shrink(dec_op_q)),
    .ovf_o      (dec_ovf),
    .unf_o      (dec_unf),
    .rd_addr_o  (dec_rd_addr),
    .wr_addr_o  (dec_wr_addr),
    .cnt_next_o (dec_cnt_next)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ex_op_q    <= OP_NOP;
      ex_sel_q   <= '0;
      ex_imm_q   <= '0;
      ex_ovf_q   <= 1'b0;
      ex_unf_q   <= 1'b0;
      ex_waddr_q <= '0;
      ex_cnt_q   <= '0;
    end else begin
      ex_op_q    <= dec_op_q;
      ex_sel_q   <= dec_sel_q;
      ex_imm_q   <= dec_imm_q;
      ex_ovf_q   <= dec_ovf;
      ex_unf_q   <= dec_unf;
      ex_waddr_q <= dec_wr_addr;
      ex_cnt_q   <= dec_cnt_next;
    end
  end

  assign ram_we = is_grow(ex_op_q) && !ex_ovf_q;

  stk_ram #(.W(W), .DEPTH(DEPTH), .AW(AW)) u_ram (
    .clk_i   (clk_i),
    .we_i    (ram_we),
    .waddr_i (ex_waddr_q),
    .wdata_i (nos_q),
    .raddr_i (dec_rd_addr),
    .rdata_o (ram_rdata)
  );

  // spill and fill hit the same slot on the same edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fwd_q      <= 1'b0;
      fwd_data_q <= '0;
    end else begin
      fwd_q      <= ram_we && (ex_waddr_q == dec_rd_addr);
      fwd_data_q <= nos_q;
    end
  end

  assign fill_data = fwd_q ? fwd_data_q : ram_rdata;

  stk_alu #(.W(W)) u_alu (
    .sel_i (ex_sel_q),
    .nos_i (nos_q),
    .tos_i (tos_q),
    .res_o (alu_res)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tos_q   <= '0;
      nos_q   <= '0;
      depth_q <= '0;
      ovf_q   <= 1'b0;
      unf_q   <= 1'b0;
    end else begin
      depth_q <= ex_cnt_q;
      ovf_q   <= ex_ovf_q;
      unf_q   <= ex_unf_q;
      unique case (ex_op_q)
        OP_PUSH: if (!ex_ovf_q) begin tos_q <= ex_imm_q; nos_q <= tos_q; end
        OP_DUP:  if (!ex_ovf_q) nos_q <= tos_q;
        OP_POP:  if (!ex_unf_q) begin tos_q <= nos_q; nos_q <= fill_data; end
        OP_ALU:  if (!ex_unf_q) begin tos_q <= alu_res; nos_q <= fill_data; end
        OP_SWAP: begin tos_q <= nos_q; nos_q <= tos_q; end
        default: ;
      endcase
    end
  end

  assign tos_o   = tos_q;
  assign nos_o   = nos_q;
  assign depth_o = depth_q;
  assign ovf_o   = ovf_q;
  assign unf_o   = unf_q;
endmodule

// File: rtl/stack_cache_chk.sv
module stack_cache_chk #(
  parameter int unsigned W     = 16,
  parameter int unsigned DEPTH = 16
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic [2:0]                 op_i,
  input logic [W-1:0]               tos_o,
  input logic [W-1:0]               nos_o,
  input logic [$clog2(DEPTH+1)-1:0] depth_o,
  input logic                       ovf_o,
  input logic                       unf_o
);
  // edges since reset; cause checks look back three samples
  logic [1:0] age_q;
  logic       armed;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             age_q <= '0;
    else if (age_q != 2'd3)  age_q <= age_q + 2'd1;
  end
  assign armed = (age_q == 2'd3);

  a_r8_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |-> (depth_o == DEPTH) && $stable(depth_o) && $stable(tos_o) && $stable(nos_o));

  a_r8_ovf_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && ovf_o) |-> ($past(op_i, 3) == 3'd1 || $past(op_i, 3) == 3'd4));

  a_r9_no_underflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unf_o |-> (depth_o == 0) && $stable(depth_o) && $stable(tos_o) && $stable(nos_o));

  a_r9_unf_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && unf_o) |-> ($past(op_i, 3) == 3'd2 || $past(op_i, 3) == 3'd3));

  a_r6_depth_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (depth_o == $past(depth_o)) || (depth_o == $past(depth_o) + 1'b1)
    || (depth_o + 1'b1 == $past(depth_o)));

  a_r2_push_grows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && !ovf_o && $past(op_i, 3) == 3'd1) |-> depth_o == $past(depth_o) + 1'b1);

  a_r5_swap_exchanges: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && $past(op_i, 3) == 3'd5) |-> (tos_o == $past(nos_o)) && (nos_o == $past(tos_o)));

  a_r10_idle_codes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && ($past(op_i, 3) == 3'd0 || $past(op_i, 3) == 3'd6 || $past(op_i, 3) == 3'd7))
    |-> $stable(tos_o) && $stable(nos_o) && $stable(depth_o) && !ovf_o && !unf_o);
endmodule

bind stack_cache stack_cache_chk #(.W(W), .DEPTH(DEPTH)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .op_i    (op_i),
  .tos_o   (tos_o),
  .nos_o   (nos_o),
  .depth_o (depth_o),
  .ovf_o   (ovf_o),
  .unf_o   (unf_o)
);

// File: tb/stack_cache_test.sv
module stack_cache_test;
  localparam int unsigned W     = 16;
  localparam int unsigned DEPTH = 16;
  localparam int unsigned CW    = $clog2(DEPTH + 1);

  typedef struct packed {
    logic [W-1:0]  tos;
    logic [W-1:0]  nos;
    logic [CW-1:0] depth;
    logic          ovf;
    logic          unf;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic [2:0]    op_i = 3'd0;
  logic [1:0]    alu_sel_i = 2'd0;
  logic [W-1:0]  imm_i = '0;
  logic [W-1:0]  tos_o, nos_o;
  logic [CW-1:0] depth_o;
  logic          ovf_o, unf_o;

  int errors = 0;
  int checks = 0;

  exp_t  exp_q[$];
  string tag_q[$];

  logic [W-1:0] m_tos = '0, m_nos = '0;
  logic [W-1:0] m_ram[$];

  always #5 clk = ~clk;

  stack_cache #(.W(W), .DEPTH(DEPTH)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .op_i(op_i), .alu_sel_i(alu_sel_i), .imm_i(imm_i),
    .tos_o(tos_o), .nos_o(nos_o), .depth_o(depth_o), .ovf_o(ovf_o), .unf_o(unf_o)
  );

  function automatic logic [W-1:0] alu_ref(input logic [1:0] s, input logic [W-1:0] a,
                                           input logic [W-1:0] b);
    case (s)
      2'd0: return a + b;
      2'd1: return a - b;
      2'd2: return a & b;
      default: return a ^ b;
    endcase
  endfunction

  task automatic drive(input logic [2:0] op, input logic [1:0] sel,
                       input logic [W-1:0] imm, input string tag);
    exp_t e;
    logic grow, shrink, ovf, unf;
    @(negedge clk);
    op_i = op; alu_sel_i = sel; imm_i = imm;
    grow   = (op == 3'd1) || (op == 3'd4);
    shrink = (op == 3'd2) || (op == 3'd3);
    ovf = grow && (m_ram.size() == DEPTH);
    unf = shrink && (m_ram.size() == 0);
    case (op)
      3'd1: if (!ovf) begin m_ram.push_back(m_nos); m_nos = m_tos; m_tos = imm; end
      3'd4: if (!ovf) begin m_ram.push_back(m_nos); m_nos = m_tos; end
      3'd2: if (!unf) begin m_tos = m_nos; m_nos = m_ram.pop_back(); end
      3'd3: if (!unf) begin m_tos = alu_ref(sel, m_nos, m_tos); m_nos = m_ram.pop_back(); end
      3'd5: begin logic [W-1:0] t; t = m_tos; m_tos = m_nos; m_nos = t; end
      default: ;
    endcase
    e.tos = m_tos; e.nos = m_nos; e.depth = CW'(m_ram.size());
    e.ovf = ovf; e.unf = unf;
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  // monitor: result of an op appears three negedges after it is driven (R6)
  always @(negedge clk) begin
    #1;
    if (exp_q.size() > 3) begin
      exp_t  e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (tos_o !== e.tos || nos_o !== e.nos || depth_o !== e.depth ||
          ovf_o !== e.ovf || unf_o !== e.unf) begin
        errors++;
        $display("FAIL %s: tos=%h nos=%h depth=%0d ovf=%b unf=%b expected tos=%h nos=%h depth=%0d ovf=%b unf=%b",
                 t, tos_o, nos_o, depth_o, ovf_o, unf_o, e.tos, e.nos, e.depth, e.ovf, e.unf);
      end
    end
  end

  initial begin
    #(200000 * 10);
    errors++; checks++;
    $display("FAIL R6 watchdog: actual=timeout expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R1 reset state
    checks++;
    if (tos_o !== '0 || nos_o !== '0 || depth_o !== '0 || ovf_o !== 1'b0 || unf_o !== 1'b0) begin
      errors++;
      $display("FAIL R1: tos=%h nos=%h depth=%0d ovf=%b unf=%b expected all zero",
               tos_o, nos_o, depth_o, ovf_o, unf_o);
    end

    // R9 pop and ALU on empty RAM
    drive(3'd2, 2'd0, '0, "R9");
    drive(3'd3, 2'd0, '0, "R9");
    // R2 pushes
    for (int i = 0; i < 5; i++) drive(3'd1, 2'd0, W'(16'h1100 + i), "R2");
    // R3 pops back to back
    for (int i = 0; i < 3; i++) drive(3'd2, 2'd0, '0, "R3");
    // R7 spill immediately followed by fill
    for (int i = 0; i < 4; i++) begin
      drive(3'd1, 2'd0, W'(16'hA0A0 + i), "R7");
      drive(3'd2, 2'd0, '0, "R7");
    end
    drive(3'd4, 2'd0, '0, "R7");
    drive(3'd3, 2'd1, '0, "R7");
    // R4 every ALU select
    for (int s = 0; s < 4; s++) begin
      drive(3'd1, 2'd0, W'(16'h0F3C + 7 * s), "R4");
      drive(3'd1, 2'd0, W'(16'h5A17 - 3 * s), "R4");
      drive(3'd3, 2'(s), '0, "R4");
    end
    // R5 dup and swap
    drive(3'd1, 2'd0, 16'hBEEF, "R5");
    drive(3'd4, 2'd0, '0, "R5");
    drive(3'd5, 2'd0, '0, "R5");
    drive(3'd1, 2'd0, 16'h1234, "R5");
    drive(3'd5, 2'd0, '0, "R5");
    // R10 idle codes
    drive(3'd0, 2'd3, 16'hFFFF, "R10");
    drive(3'd6, 2'd1, 16'h7777, "R10");
    drive(3'd7, 2'd2, 16'h3333, "R10");
    // R8 fill past full with push and dup
    for (int i = 0; i < DEPTH + 2; i++) drive(3'd1, 2'd0, W'(16'h2000 + i), "R8");
    drive(3'd4, 2'd0, '0, "R8");
    drive(3'd2, 2'd0, '0, "R8");
    drive(3'd4, 2'd0, '0, "R8");
    drive(3'd4, 2'd0, '0, "R8");
    // R9 drain past empty
    for (int i = 0; i < DEPTH + 3; i++) drive((i % 3 == 0) ? 3'd3 : 3'd2, 2'(i), '0, "R9");
    // R6 random back-to-back mix
    for (int i = 0; i < 3000; i++) begin
      int r;
      logic [2:0] op;
      r = $urandom_range(0, 99);
      if (r < 35)      op = 3'd1;
      else if (r < 55) op = 3'd2;
      else if (r < 70) op = 3'd3;
      else if (r < 80) op = 3'd4;
      else if (r < 90) op = 3'd5;
      else             op = 3'($urandom_range(0, 7));
      drive(op, 2'($urandom_range(0, 3)), W'($urandom), "R6");
    end
    for (int i = 0; i < 3; i++) drive(3'd0, 2'd0, '0, "R10");
    @(negedge clk);
    #2;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule